// File: doc/BRIEF.md
# Packet Page Allocator

This block hands out fixed-size 256-byte pages of a shared packet buffer to transmit and receive traffic in an Ethernet controller. A host drives it through an 8-bit command port and a packet-number register. The commands allocate a numbered packet, reset the whole pool, drop or release the packet at the head of the receive queue, free a packet by number, queue a packet for transmit, and clear the transmit queue.

Allocation is a short search that takes a fixed number of cycles. During that search, and during a release, the block reports busy and drops any further command. The host polls the result byte, or the allocation-done flag, to learn the packet number it was granted or that the request failed.

Two packet-number queues are visible in one 16-bit status word. The receive queue is fed by a simple push port that stands in for the receive MAC. The transmit queue is fed by the enqueue command. A second 16-bit word reports how many pages are free and how many exist in total.

Top module: `pkt_page_alloc`

## Requirements
- R1: The opcode is taken from command bits 7:5. Opcode 0 has no effect on any output, whatever the low bits hold.
- R2: Opcode 1 (allocate) requests `cmd[4:0]+1` pages. The grant goes to the lowest unused packet number and to the lowest-addressed contiguous run of free pages. Two clock edges after the command is accepted, the result byte holds the packet number in bits 6:0 with bit 7 clear, and the free-page count has dropped by the run length.
- R3: An allocation fails when no packet number is unused or no contiguous run is long enough. This includes requests larger than the pool. On failure the result byte reads 0x80 and no page is taken.
- R4: The allocation-done flag rises when an allocation completes, whether it succeeded or failed. It clears when the next allocate is accepted or when the pool is reset.
- R5: Bit 0 of the status byte is 1 during the two cycles of an allocation and the one cycle of a release, and 0 otherwise. A command written while busy is dropped.
- R6: Opcode 5 frees the packet held in the packet-number register. Its pages return one cycle after the busy cycle begins. Freeing a packet that is not allocated is ignored: busy stays 0 and no count changes.
- R7: Opcode 6 pushes the packet-number register onto the transmit queue, but only if that packet is allocated. Otherwise the command is ignored.
- R8: The queue word carries the receive head in bits 14:8 with a receive-empty flag in bit 15. It carries the transmit head in bits 6:0 with a transmit-empty flag in bit 7. A head field reads 0 while its queue is empty.
- R9: The receive push port appends a packet number in arrival order. A push is dropped when the queue is full or the number is not below the packet count. A push and a head removal in the same cycle both take effect.
- R10: Opcode 3 removes the receive head and keeps its pages allocated.
- R11: Opcode 4 removes the receive head and frees its pages after one busy cycle. It is ignored when the receive queue is empty.
- R12: Opcode 7 empties the transmit queue and leaves the receive queue untouched.
- R13: Opcode 2 returns every page and every packet number to the pool and empties both queues. It also sets the result byte to 0x80 and clears the allocation-done flag. This is also the state after the reset input.
- R14: The memory word reports free pages in bits 15:8 and the total page count in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command word: opcode in 7:5, page count minus one in 4:0 |
| pn_we | input | 1 | Packet-number register write strobe |
| pn_wdata | input | 7 | Packet number used by free and enqueue |
| rx_push | input | 1 | Receive side pushes a packet number |
| rx_pnum | input | 7 | Packet number being pushed |
| cmd_status | output | 8 | Bit 0 is busy; other bits read 0 |
| alloc_result | output | 8 | Granted packet number, bit 7 set on failure |
| alloc_irq | output | 1 | Allocation-done flag |
| queue_word | output | 16 | Receive and transmit queue heads with empty flags |
| mem_info | output | 16 | Free pages (15:8) and total pages (7:0) |

## Verification
The receive push port and a head-removing command can land on the same clock edge. The bench provokes this by driving a push and a remove opcode in one cycle while the queue already holds two entries. It then judges the result by the head numbers that appear over the following removals. The other collision is a command that arrives during an allocation search. The bench writes a valid enqueue in the middle busy cycle and checks that the transmit side of the queue word stays empty after the grant appears.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RX_DROP = 3'd3,
    OP_RX_FREE = 3'd4,
    OP_FREE_PN = 3'd5,
    OP_TX_ENQ  = 3'd6,
    OP_TX_CLR  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEARCH  = 2'd1,
    ST_COMMIT  = 2'd2,
    ST_RELEASE = 2'd3
  } st_e;

  localparam logic [7:0] RESULT_NONE = 8'h80;

  // Both queue views packed into one status word; empty queues show head 0.
  function automatic logic [15:0] pack_queues(input logic rx_empty, input logic [6:0] rx_head,
                                              input logic tx_empty, input logic [6:0] tx_head);
    return {rx_empty, rx_empty ? 7'd0 : rx_head, tx_empty, tx_empty ? 7'd0 : tx_head};
  endfunction

endpackage

// File: rtl/pa_pnum_fifo.sv
module pa_pnum_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CNTW-1:0] cnt;
  logic            do_pop, do_push;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNTW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/pa_page_map.sv
module pa_page_map #(
  parameter int NPAGE = 16,
  parameter int LENW  = 6,
  parameter int PGW   = $clog2(NPAGE),
  parameter int CW    = $clog2(NPAGE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [LENW-1:0]  need,
  input  logic             srch_en,
  input  logic             take_en,
  input  logic [PGW-1:0]   take_base,
  input  logic [LENW-1:0]  take_len,
  input  logic             give_en,
  input  logic [PGW-1:0]   give_base,
  input  logic [LENW-1:0]  give_len,
  output logic [NPAGE-1:0] free_map,
  output logic [CW-1:0]    free_cnt,
  output logic             srch_found,
  output logic [PGW-1:0]   srch_base
);

  // Pages [base, base+len) as a bit mask.
  function automatic logic [NPAGE-1:0] run_mask(input int base, input int len);
    logic [NPAGE-1:0] m;
    for (int i = 0; i < NPAGE; i++) m[i] = (i >= base) && (i < base + len);
    return m;
  endfunction

  logic             hit;
  logic [PGW-1:0]   at;
  logic [NPAGE-1:0] take_m, give_m, nxt_map;

  // First fit: scan downward so the lowest fitting base wins.
  always_comb begin
    hit = 1'b0;
    at  = '0;
    for (int b = NPAGE - 1; b >= 0; b--) begin
      if (b + int'(need) <= NPAGE) begin
        if ((free_map & run_mask(b, int'(need))) == run_mask(b, int'(need))) begin
          hit = 1'b1;
          at  = PGW'(b);
        end
      end
    end
  end

  assign take_m = run_mask(int'(take_base), int'(take_len));
  assign give_m = run_mask(int'(give_base), int'(give_len));

  for (genvar g = 0; g < NPAGE; g++) begin : g_page
    assign nxt_map[g] = clr_all                   ? 1'b1 :
                        (give_en && give_m[g])    ? 1'b1 :
                        (take_en && take_m[g])    ? 1'b0 : free_map[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map   <= '1;
      srch_found <= 1'b0;
      srch_base  <= '0;
    end else begin
      free_map <= nxt_map;
      if (srch_en) begin
        srch_found <= hit;
        srch_base  <= at;
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < NPAGE; i++) free_cnt = free_cnt + CW'(free_map[i]);
  end

endmodule

// File: rtl/pa_pkt_table.sv
module pa_pkt_table #(
  parameter int NPKT = 8,
  parameter int PGW  = 4,
  parameter int LENW = 6,
  parameter int PNW  = $clog2(NPKT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all,
  input  logic            set_en,
  input  logic [PNW-1:0]  set_idx,
  input  logic [PGW-1:0]  set_base,
  input  logic [LENW-1:0] set_len,
  input  logic            clr_en,
  input  logic [PNW-1:0]  clr_idx,
  input  logic [PNW-1:0]  look_idx,
  output logic [NPKT-1:0] valid_vec,
  output logic            look_valid,
  output logic [PGW-1:0]  look_base,
  output logic [LENW-1:0] look_len,
  output logic            free_hit,
  output logic [PNW-1:0]  free_idx
);
  logic [PGW-1:0]  base_q [NPKT];
  logic [LENW-1:0] len_q  [NPKT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
      for (int i = 0; i < NPKT; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else if (clr_all) begin
      valid_vec <= '0;
    end else begin
      if (clr_en) valid_vec[clr_idx] <= 1'b0;
      if (set_en) begin
        valid_vec[set_idx] <= 1'b1;
        base_q[set_idx]    <= set_base;
        len_q[set_idx]     <= set_len;
      end
    end
  end

  assign look_valid = valid_vec[look_idx];
  assign look_base  = base_q[look_idx];
  assign look_len   = len_q[look_idx];

  // Lowest unused packet number.
  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = NPKT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_hit = 1'b1;
        free_idx = PNW'(i);
      end
    end
  end

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int NPKT  = 8,
  parameter int NPAGE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_wdata,
  input  logic        pn_we,
  input  logic [6:0]  pn_wdata,
  input  logic        rx_push,
  input  logic [6:0]  rx_pnum,
  output logic [7:0]  cmd_status,
  output logic [7:0]  alloc_result,
  output logic        alloc_irq,
  output logic [15:0] queue_word,
  output logic [15:0] mem_info
);
  import pa_pkg::*;

  localparam int PNW  = (NPKT > 1) ? $clog2(NPKT) : 1;
  localparam int PGW  = (NPAGE > 1) ? $clog2(NPAGE) : 1;
  localparam int LENW = 6;
  localparam int CW   = $clog2(NPAGE + 1);

  st_e             state;
  op_e             op;
  logic [LENW-1:0] need_q;
  logic [PNW-1:0]  rel_idx_q;
  logic [6:0]      pn_reg;

  logic [NPKT-1:0] pkt_valid;
  logic            look_valid, free_hit;
  logic [PGW-1:0]  look_base, srch_base;
  logic [LENW-1:0] look_len;
  logic [PNW-1:0]  free_idx, pn_idx;
  logic [NPAGE-1:0] free_map;
  logic [CW-1:0]   free_cnt;
  logic            srch_found;

  logic [PNW-1:0]  rx_head, tx_head;
  logic            rx_empty, rx_full, tx_empty, tx_full;

  // Named internal events, also observed by the bound checker.
  logic busy, idle, acc, pn_ok;
  logic ev_alloc_acc, ev_reset, ev_rx_drop, ev_rx_free, ev_pn_free;
  logic ev_release_acc, ev_release_done, ev_tx_enq, ev_tx_clr;
  logic ev_commit, ev_alloc_ok, ev_rx_push;

  assign op     = op_e'(cmd_wdata[7:5]);
  assign idle   = (state == ST_IDLE);
  assign busy   = !idle;
  assign acc    = cmd_we && idle;
  assign pn_idx = pn_reg[PNW-1:0];
  assign pn_ok  = (pn_reg < 7'(NPKT)) && pkt_valid[pn_idx];

  assign ev_alloc_acc    = acc && (op == OP_ALLOC);
  assign ev_reset        = acc && (op == OP_RESET);
  assign ev_rx_drop      = acc && (op == OP_RX_DROP) && !rx_empty;
  assign ev_rx_free      = acc && (op == OP_RX_FREE) && !rx_empty;
  assign ev_pn_free      = acc && (op == OP_FREE_PN) && pn_ok;
  assign ev_tx_enq       = acc && (op == OP_TX_ENQ) && pn_ok;
  assign ev_tx_clr       = acc && (op == OP_TX_CLR);
  assign ev_release_acc  = ev_rx_free || ev_pn_free;
  assign ev_release_done = (state == ST_RELEASE);
  assign ev_commit       = (state == ST_COMMIT);
  assign ev_alloc_ok     = ev_commit && srch_found && free_hit;
  assign ev_rx_push      = rx_push && (rx_pnum < 7'(NPKT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      need_q       <= '0;
      rel_idx_q    <= '0;
      pn_reg       <= '0;
      alloc_result <= RESULT_NONE;
      alloc_irq    <= 1'b0;
    end else begin
      if (pn_we) pn_reg <= pn_wdata;
      unique case (state)
        ST_IDLE: begin
          if (ev_alloc_acc) begin
            need_q    <= LENW'(cmd_wdata[4:0]) + LENW'(1);
            alloc_irq <= 1'b0;
            state     <= ST_SEARCH;
          end else if (ev_release_acc) begin
            rel_idx_q <= ev_rx_free ? rx_head : pn_idx;
            state     <= ST_RELEASE;
          end else if (ev_reset) begin
            alloc_result <= RESULT_NONE;
            alloc_irq    <= 1'b0;
          end
        end
        ST_SEARCH: state <= ST_COMMIT;
        ST_COMMIT: begin
          alloc_result <= ev_alloc_ok ? {1'b0, 7'(free_idx)} : RESULT_NONE;
          alloc_irq    <= 1'b1;
          state        <= ST_IDLE;
        end
        ST_RELEASE: state <= ST_IDLE;
      endcase
    end
  end

  pa_page_map #(.NPAGE(NPAGE), .LENW(LENW), .PGW(PGW), .CW(CW)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (ev_reset),
    .need       (need_q),
    .srch_en    (state == ST_SEARCH),
    .take_en    (ev_alloc_ok),
    .take_base  (srch_base),
    .take_len   (need_q),
    .give_en    (ev_release_done && look_valid),
    .give_base  (look_base),
    .give_len   (look_len),
    .free_map   (free_map),
    .free_cnt   (free_cnt),
    .srch_found (srch_found),
    .srch_base  (srch_base)
  );

  pa_pkt_table #(.NPKT(NPKT), .PGW(PGW), .LENW(LENW), .PNW(PNW)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (ev_reset),
    .set_en     (ev_alloc_ok),
    .set_idx    (free_idx),
    .set_base   (srch_base),
    .set_len    (need_q),
    .clr_en     (ev_release_done),
    .clr_idx    (rel_idx_q),
    .look_idx   (rel_idx_q),
    .valid_vec  (pkt_valid),
    .look_valid (look_valid),
    .look_base  (look_base),
    .look_len   (look_len),
    .free_hit   (free_hit),
    .free_idx   (free_idx)
  );

  pa_pnum_fifo #(.DEPTH(NPKT), .W(PNW)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_reset),
    .push  (ev_rx_push),
    .din   (rx_pnum[PNW-1:0]),
    .pop   (ev_rx_drop || ev_rx_free),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full)
  );

  pa_pnum_fifo #(.DEPTH(NPKT), .W(PNW)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_reset || ev_tx_clr),
    .push  (ev_tx_enq),
    .din   (pn_idx),
    .pop   (1'b0),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full)
  );

  assign cmd_status = {7'd0, busy};
  assign queue_word = pack_queues(rx_empty, 7'(rx_head), tx_empty, 7'(tx_head));
  assign mem_info   = {8'(free_cnt), 8'(NPAGE)};

endmodule

// File: rtl/pa_checker.sv
module pa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [7:0]  alloc_result,
  input logic        alloc_irq,
  input logic [15:0] queue_word,
  input logic [15:0] mem_info,
  input logic        ev_alloc_acc,
  input logic        ev_commit,
  input logic        ev_release_acc,
  input logic        ev_release_done,
  input logic        ev_reset
);

  p_fail_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_result[7] |-> (alloc_result[6:0] == 7'd0));

  p_commit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> $past(ev_alloc_acc, 2));

  p_free_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_info[15:8] < $past(mem_info[15:8])) |-> $past(ev_commit));

  p_irq_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_irq) |-> $past(ev_commit));

  p_release_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release_acc |=> (busy && ev_release_done));

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  p_free_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_info[15:8] > $past(mem_info[15:8])) |-> ($past(ev_release_done) || $past(ev_reset)));

  p_empty_heads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_word[15] |-> (queue_word[14:8] == 7'd0)) and (queue_word[7] |-> (queue_word[6:0] == 7'd0)));

  p_reset_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> ((mem_info[15:8] == mem_info[7:0]) && (queue_word == 16'h8080) && !alloc_irq));

  p_free_le_total_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_info[15:8] <= mem_info[7:0]);

endmodule

bind pkt_page_alloc pa_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy            (busy),
  .alloc_result    (alloc_result),
  .alloc_irq       (alloc_irq),
  .queue_word      (queue_word),
  .mem_info        (mem_info),
  .ev_alloc_acc    (ev_alloc_acc),
  .ev_commit       (ev_commit),
  .ev_release_acc  (ev_release_acc),
  .ev_release_done (ev_release_done),
  .ev_reset        (ev_reset)
);

// File: tb/tb_pkt_page_alloc.sv
module tb_pkt_page_alloc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        pn_we = 1'b0;
  logic [6:0]  pn_wdata = 7'd0;
  logic        rx_push = 1'b0;
  logic [6:0]  rx_pnum = 7'd0;
  logic [7:0]  cmd_status, alloc_result;
  logic        alloc_irq;
  logic [15:0] queue_word, mem_info;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pkt_page_alloc dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .pn_we(pn_we), .pn_wdata(pn_wdata), .rx_push(rx_push), .rx_pnum(rx_pnum),
    .cmd_status(cmd_status), .alloc_result(alloc_result), .alloc_irq(alloc_irq),
    .queue_word(queue_word), .mem_info(mem_info)
  );

  // {command, expected result byte, expected free pages}, 16 pages, 8 packet numbers
  localparam logic [23:0] VEC [6] = '{
    24'h23_00_0C,  // 4 pages -> pkt 0, pages 0..3
    24'h20_01_0B,  // 1 page  -> pkt 1, page 4
    24'h27_02_03,  // 8 pages -> pkt 2, pages 5..12
    24'h23_80_03,  // 4 pages, only 3 left -> fail
    24'h22_03_00,  // 3 pages -> pkt 3, pages 13..15
    24'h20_80_00   // pool exhausted -> fail
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic do_alloc(input logic [7:0] c);
    put_cmd(c);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pn(input logic [6:0] p);
    @(negedge clk); pn_we = 1'b1; pn_wdata = p;
    @(negedge clk); pn_we = 1'b0;
  endtask

  task automatic push_rx(input logic [6:0] p);
    @(negedge clk); rx_push = 1'b1; rx_pnum = p;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset result", {8'h0, alloc_result}, 16'h0080);
    check("R13 reset irq", {15'h0, alloc_irq}, 16'h0000);
    check("R5 reset status", {8'h0, cmd_status}, 16'h0000);
    check("R8 reset queues", queue_word, 16'h8080);
    check("R14 reset mem info", mem_info, 16'h1010);

    // R2 R3 table walk
    for (int i = 0; i < 6; i++) begin
      do_alloc(VEC[i][23:16]);
      check("R2 R3 alloc result", {8'h0, alloc_result}, {8'h0, VEC[i][15:8]});
      check("R2 R3 free pages", mem_info, {VEC[i][7:0], 8'h10});
      check("R4 done flag", {15'h0, alloc_irq}, 16'h0001);
    end

    // R1 opcode 0 with low bits set
    put_cmd(8'h1F);
    check("R1 nop mem", mem_info, 16'h0010);
    check("R1 nop result", {8'h0, alloc_result}, 16'h0080);
    check("R1 nop queues", queue_word, 16'h8080);
    check("R1 nop status", {8'h0, cmd_status}, 16'h0000);

    // R6 free packet 1 (one page)
    set_pn(7'd1);
    put_cmd(8'hA0);
    check("R5 release busy", {8'h0, cmd_status}, 16'h0001);
    @(negedge clk);
    check("R5 release done", {8'h0, cmd_status}, 16'h0000);
    check("R6 pages returned", mem_info, 16'h0110);
    put_cmd(8'hA0);
    check("R6 double free no busy", {8'h0, cmd_status}, 16'h0000);
    check("R6 double free ignored", mem_info, 16'h0110);

    // R3 one free page cannot hold two
    do_alloc(8'h21);
    check("R3 no contiguous run", {8'h0, alloc_result}, 16'h0080);
    check("R3 nothing taken", mem_info, 16'h0110);

    // R2 reuse of number 1; R5 enqueue during search is dropped
    set_pn(7'd0);
    put_cmd(8'h20);
    check("R5 alloc busy", {8'h0, cmd_status}, 16'h0001);
    check("R4 flag cleared on accept", {15'h0, alloc_irq}, 16'h0000);
    cmd_we = 1'b1; cmd_wdata = 8'hC0;
    @(negedge clk); cmd_we = 1'b0;
    @(negedge clk);
    check("R2 lowest free number", {8'h0, alloc_result}, 16'h0001);
    check("R2 page taken", mem_info, 16'h0010);
    check("R4 flag set", {15'h0, alloc_irq}, 16'h0001);
    check("R5 busy command dropped", queue_word, 16'h8080);

    // R7 enqueue
    put_cmd(8'hC0);
    check("R7 enqueue pkt 0", queue_word, 16'h8000);
    set_pn(7'd5);
    put_cmd(8'hC0);
    check("R7 unallocated ignored", queue_word, 16'h8000);
    set_pn(7'd2);
    put_cmd(8'hC0);
    check("R7 order kept", queue_word, 16'h8000);

    // R9 receive pushes
    push_rx(7'd3);
    push_rx(7'd2);
    check("R9 rx head first in", queue_word, 16'h0300);

    // R12 transmit clear
    put_cmd(8'hE0);
    check("R12 tx cleared rx kept", queue_word, 16'h0380);

    // R10 remove keeps pages
    put_cmd(8'h60);
    check("R10 head advanced", queue_word, 16'h0280);
    check("R10 pages kept", mem_info, 16'h0010);

    // R11 release head (pkt 2, eight pages)
    put_cmd(8'h80);
    check("R11 busy", {8'h0, cmd_status}, 16'h0001);
    @(negedge clk);
    check("R11 pages freed", mem_info, 16'h0810);
    check("R11 queue empty", queue_word, 16'h8080);
    put_cmd(8'h80);
    check("R11 empty release no busy", {8'h0, cmd_status}, 16'h0000);
    check("R11 empty release ignored", mem_info, 16'h0810);

    // R9 push and remove in one cycle
    push_rx(7'd0);
    push_rx(7'd1);
    @(negedge clk);
    rx_push = 1'b1; rx_pnum = 7'd3; cmd_we = 1'b1; cmd_wdata = 8'h60;
    @(negedge clk);
    rx_push = 1'b0; cmd_we = 1'b0;
    check("R9 same cycle pop", queue_word, 16'h0180);
    put_cmd(8'h60);
    check("R9 same cycle push kept", queue_word, 16'h0380);
    put_cmd(8'h60);
    check("R9 drained", queue_word, 16'h8080);

    // R13 pool reset
    put_cmd(8'h40);
    check("R13 mem restored", mem_info, 16'h1010);
    check("R13 result cleared", {8'h0, alloc_result}, 16'h0080);
    check("R13 flag cleared", {15'h0, alloc_irq}, 16'h0000);
    check("R13 queues empty", queue_word, 16'h8080);

    // R9 full queue and out-of-range numbers drop
    for (int i = 0; i < 8; i++) push_rx(7'(i));
    push_rx(7'd7);
    push_rx(7'd9);
    for (int i = 0; i < 7; i++) put_cmd(8'h60);
    check("R9 last kept entry", queue_word, 16'h0780);
    put_cmd(8'h60);
    check("R9 overflow dropped", queue_word, 16'h8080);

    // R3 oversize request, R2 whole pool
    do_alloc(8'h30);
    check("R3 oversize fails", {8'h0, alloc_result}, 16'h0080);
    check("R3 oversize nothing taken", mem_info, 16'h1010);
    do_alloc(8'h2F);
    check("R2 whole pool", {8'h0, alloc_result}, 16'h0000);
    check("R14 free count zero", mem_info, 16'h0010);

    finish_run();
  end

endmodule